// File: doc/BRIEF.md
# Configuration Readback Command Sequencer

This controller drives the 32-bit parallel configuration port of a programmable device through the full command sequence needed to read configuration frames back. A single-cycle start pulse latches a starting frame address, a words-per-frame count and a frame count. The sequencer then writes the synchronisation, CRC-reset, shutdown, read-configuration and frame-address words. It computes the frame-data read length and issues that read as a type-1 header followed by a type-2 header that carries the length. Two flush words follow the header.

The sequencer then pulls the computed number of words from the port. The leading buffered frame and the single trailing pad word are dropped. Only the real frame words go to a valid/ready stream, and port reads stall whenever a forwardable word meets a downstream that is not ready. After the read, the sequencer writes the restart, CRC-reset and desynchronise words and a 64-bit no-op tail. It then keeps writing no-ops until the device's done line rises. If done does not rise within a parameterised number of cycles, the run is abandoned with a timeout flag.

All command encodings are parameters. Port pin timing, the byte-wide port mode and CRC checking are not handled here.

Top module: `cfg_readback_seq`

## Requirements
- R1: After reset the block is idle: busy_o, timeout_o, port_wr_o, port_rd_o and m_valid_o are all 0.
- R2: In the cycles that follow the clock edge that accepts start_i, port_wr_o is 1 and port_wdata_o carries these 20 words, one per cycle, in this order: sync, no-op, cmd header, CRC-reset code, no-op, no-op, cmd header, shutdown code, four no-ops, cmd header, read-config code, frame-address header, start address, frame-data type-1 header, type-2 length header, dummy, dummy.
- R3: The type-2 length header equals the type-2 header parameter OR-ed with L = words_per_frame × (frame_count + 1) + 1 in bits [26:0].
- R4: Starting with the cycle after the second dummy word, port_wr_o is 0 and exactly L port reads (port_rd_o = 1) are made. A read never coincides with a write.
- R5: Read number k (counting from 0) is forwarded on m_data_o with m_valid_o = 1 exactly when words_per_frame ≤ k < L − 1. The first frame and the last word are dropped, and forwarded words keep their order.
- R6: A forwardable word is read only in a cycle where m_ready_i is 1. A word that is dropped is read without regard to m_ready_i.
- R7: After the last read, 9 words are written: no-op, cmd header, start code, cmd header, CRC-reset code, cmd header, desynchronise code, no-op, no-op.
- R8: After that, a no-op is written every cycle until done_i is seen high at a clock edge. The block is idle from the next cycle.
- R9: busy_o is 1 from the cycle after start is accepted until the block returns to idle.
- R10: If done_i stays low for TIMEOUT_CYCLES cycles of the no-op wait, the block goes idle and sets timeout_o. timeout_o stays set until the next accepted start clears it.
- R11: start_i is ignored while busy. The address and counts are captured only on the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| frame_addr_i | input | 32 | Starting frame address |
| words_per_frame_i | input | WPF_W | Words in one frame |
| frame_count_i | input | FC_W | Number of frames to return |
| port_wr_o | output | 1 | Port write strobe |
| port_wdata_o | output | 32 | Port write word |
| port_rd_o | output | 1 | Port read strobe; consumes port_rdata_i |
| port_rdata_i | input | 32 | Next readback word offered by the port |
| done_i | input | 1 | Device done line |
| m_valid_o | output | 1 | Readback stream valid |
| m_ready_i | input | 1 | Readback stream ready |
| m_data_o | output | 32 | Readback stream word |
| busy_o | output | 1 | Sequence in progress |
| timeout_o | output | 1 | Done did not rise in time |

## Verification
The first command word appears in the cycle right after the edge that accepts start. Each later write follows one cycle after the one before it. Read strobes and stream valid/data are combinational in port_rdata_i, m_ready_i and the sequencer state, so they are due in the same cycle as the inputs that enable them. Return to idle and the timeout flag follow one edge after done, or after the last wait cycle. The bench holds a behavioural model that steps at each rising edge on the same inputs as the design, drives inputs shortly after that edge, and compares every output at the falling edge. Each comparison therefore falls inside the cycle in which the result is due.

// File: rtl/cfg_rb_pkg.sv
package cfg_rb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_READ, ST_POST, ST_WAIT
  } seq_state_e;

  localparam int PRE_N  = 20;
  localparam int POST_N = 9;
  localparam int STEP_W = 5;
  localparam int LEN_FIELD_W = 27;
endpackage

// File: rtl/cfg_rb_wordgen.sv
module cfg_rb_wordgen
  import cfg_rb_pkg::*;
#(
  parameter int LEN_W = 17,
  parameter logic [31:0] SYNC_WORD = 32'hAA99_5566,
  parameter logic [31:0] NOOP_WORD = 32'h2000_0000,
  parameter logic [31:0] DUMMY_WORD = 32'hFFFF_FFFF,
  parameter logic [31:0] CMD_HDR = 32'h3000_8001,
  parameter logic [31:0] FAR_HDR = 32'h3000_2001,
  parameter logic [31:0] FDRO_HDR = 32'h2800_6000,
  parameter logic [31:0] TYPE2_RD_HDR = 32'h4800_0000,
  parameter logic [31:0] RCRC_CODE = 32'h0000_0007,
  parameter logic [31:0] SHUTDOWN_CODE = 32'h0000_000B,
  parameter logic [31:0] RCFG_CODE = 32'h0000_0004,
  parameter logic [31:0] START_CODE = 32'h0000_0005,
  parameter logic [31:0] DESYNC_CODE = 32'h0000_000D
) (
  input  seq_state_e        state_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [31:0]       addr_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [31:0]       word_o
);
  logic [31:0] len_word;
  assign len_word = TYPE2_RD_HDR | {{(32-LEN_FIELD_W){1'b0}}, LEN_FIELD_W'(len_i)};

  always_comb begin
    word_o = NOOP_WORD;
    if (state_i == ST_PRE) begin
      unique case (step_i)
        5'd0:                 word_o = SYNC_WORD;
        5'd2, 5'd6, 5'd12:    word_o = CMD_HDR;
        5'd3:                 word_o = RCRC_CODE;
        5'd7:                 word_o = SHUTDOWN_CODE;
        5'd13:                word_o = RCFG_CODE;
        5'd14:                word_o = FAR_HDR;
        5'd15:                word_o = addr_i;
        5'd16:                word_o = FDRO_HDR;
        5'd17:                word_o = len_word;
        5'd18, 5'd19:         word_o = DUMMY_WORD;
        default:              word_o = NOOP_WORD;
      endcase
    end else if (state_i == ST_POST) begin
      unique case (step_i)
        5'd1, 5'd3, 5'd5:     word_o = CMD_HDR;
        5'd2:                 word_o = START_CODE;
        5'd4:                 word_o = RCRC_CODE;
        5'd6:                 word_o = DESYNC_CODE;
        default:              word_o = NOOP_WORD;
      endcase
    end
  end
endmodule

// File: rtl/cfg_rb_readctl.sv
module cfg_rb_readctl #(
  parameter int WPF_W = 8,
  parameter int LEN_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             rd_fire_i,
  input  logic [WPF_W-1:0] wpf_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             fwd_o,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!active_i)            cnt_q <= '0;
    else if (rd_fire_i && !last_o) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == len_i - 1'b1);
  assign fwd_o  = (cnt_q >= LEN_W'(wpf_i)) && !last_o;

  // R4: reads never run past the computed length
  assert_cnt_in_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> cnt_q < len_i);
  // R5: the word after the dropped frame is forwarded only on a real read
  assert_fwd_advances_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && fwd_o && !rd_fire_i) |=> (active_i && fwd_o));
endmodule

// File: rtl/cfg_rb_watchdog.sv
module cfg_rb_watchdog #(
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic expire_o
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (!en_i)     cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = en_i && (cnt_q == CW'(TIMEOUT_CYCLES - 1));

  // R10: the wait count never exceeds the limit
  assert_wd_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(TIMEOUT_CYCLES));
endmodule

// File: rtl/cfg_readback_seq.sv
module cfg_readback_seq
  import cfg_rb_pkg::*;
#(
  parameter int WPF_W = 8,
  parameter int FC_W = 8,
  parameter int TIMEOUT_CYCLES = 4096,
  parameter logic [31:0] SYNC_WORD = 32'hAA99_5566,
  parameter logic [31:0] NOOP_WORD = 32'h2000_0000,
  parameter logic [31:0] DUMMY_WORD = 32'hFFFF_FFFF,
  parameter logic [31:0] CMD_HDR = 32'h3000_8001,
  parameter logic [31:0] FAR_HDR = 32'h3000_2001,
  parameter logic [31:0] FDRO_HDR = 32'h2800_6000,
  parameter logic [31:0] TYPE2_RD_HDR = 32'h4800_0000,
  parameter logic [31:0] RCRC_CODE = 32'h0000_0007,
  parameter logic [31:0] SHUTDOWN_CODE = 32'h0000_000B,
  parameter logic [31:0] RCFG_CODE = 32'h0000_0004,
  parameter logic [31:0] START_CODE = 32'h0000_0005,
  parameter logic [31:0] DESYNC_CODE = 32'h0000_000D
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [31:0]      frame_addr_i,
  input  logic [WPF_W-1:0] words_per_frame_i,
  input  logic [FC_W-1:0]  frame_count_i,
  output logic             port_wr_o,
  output logic [31:0]      port_wdata_o,
  output logic             port_rd_o,
  input  logic [31:0]      port_rdata_i,
  input  logic             done_i,
  output logic             m_valid_o,
  input  logic             m_ready_i,
  output logic [31:0]      m_data_o,
  output logic             busy_o,
  output logic             timeout_o
);
  localparam int LEN_W = WPF_W + FC_W + 1;

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [31:0]       addr_q;
  logic [WPF_W-1:0]  wpf_q;
  logic [FC_W-1:0]   fc_q;
  logic [LEN_W-1:0]  len;
  logic              fwd, last, rd_fire, wd_expire;

  // read length: one extra frame for the frame buffer, one extra pad word
  assign len = LEN_W'(wpf_q) * (LEN_W'(fc_q) + 1'b1) + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      step_q    <= '0;
      addr_q    <= '0;
      wpf_q     <= '0;
      fc_q      <= '0;
      timeout_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q   <= ST_PRE;
          step_q    <= '0;
          addr_q    <= frame_addr_i;
          wpf_q     <= words_per_frame_i;
          fc_q      <= frame_count_i;
          timeout_o <= 1'b0;
        end
        ST_PRE: begin
          step_q <= (step_q == STEP_W'(PRE_N - 1)) ? '0 : step_q + 1'b1;
          if (step_q == STEP_W'(PRE_N - 1)) state_q <= ST_READ;
        end
        ST_READ: if (rd_fire && last) begin
          state_q <= ST_POST;
          step_q  <= '0;
        end
        ST_POST: begin
          step_q <= step_q + 1'b1;
          if (step_q == STEP_W'(POST_N - 1)) state_q <= ST_WAIT;
        end
        ST_WAIT: if (done_i) begin
          state_q <= ST_IDLE;
        end else if (wd_expire) begin
          state_q   <= ST_IDLE;
          timeout_o <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  cfg_rb_wordgen #(
    .LEN_W(LEN_W), .SYNC_WORD(SYNC_WORD), .NOOP_WORD(NOOP_WORD),
    .DUMMY_WORD(DUMMY_WORD), .CMD_HDR(CMD_HDR), .FAR_HDR(FAR_HDR),
    .FDRO_HDR(FDRO_HDR), .TYPE2_RD_HDR(TYPE2_RD_HDR), .RCRC_CODE(RCRC_CODE),
    .SHUTDOWN_CODE(SHUTDOWN_CODE), .RCFG_CODE(RCFG_CODE),
    .START_CODE(START_CODE), .DESYNC_CODE(DESYNC_CODE)
  ) u_wordgen (
    .state_i(state_q), .step_i(step_q), .addr_i(addr_q),
    .len_i(len), .word_o(port_wdata_o)
  );

  cfg_rb_readctl #(.WPF_W(WPF_W), .LEN_W(LEN_W)) u_readctl (
    .clk_i, .rst_ni, .active_i(state_q == ST_READ), .rd_fire_i(rd_fire),
    .wpf_i(wpf_q), .len_i(len), .fwd_o(fwd), .last_o(last)
  );

  cfg_rb_watchdog #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_wd (
    .clk_i, .rst_ni, .en_i(state_q == ST_WAIT && !done_i), .expire_o(wd_expire)
  );

  assign port_wr_o = (state_q == ST_PRE) || (state_q == ST_POST) || (state_q == ST_WAIT);
  assign rd_fire   = (state_q == ST_READ) && (!fwd || m_ready_i);
  assign port_rd_o = rd_fire;
  assign m_valid_o = (state_q == ST_READ) && fwd;
  assign m_data_o  = port_rdata_i;
  assign busy_o    = (state_q != ST_IDLE);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!port_wr_o && !port_rd_o && !m_valid_o));
  assert_rd_wr_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(port_rd_o && port_wr_o));
  assert_handshake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && m_ready_i) |-> port_rd_o);
  assert_stall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_valid_o && !m_ready_i) |-> !port_rd_o);
  assert_timeout_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !busy_o);
  assert_busy_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(addr_q));
endmodule

// File: tb/cfg_readback_seq_test.sv
module cfg_readback_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int TO_CYC = 40;
  localparam logic [31:0] W_SYNC = 32'hAA99_5566, W_NOOP = 32'h2000_0000,
    W_DUMMY = 32'hFFFF_FFFF, H_CMD = 32'h3000_8001, H_FAR = 32'h3000_2001,
    H_FDRO = 32'h2800_6000, H_T2 = 32'h4800_0000, C_RCRC = 32'h7,
    C_SHUT = 32'hB, C_RCFG = 32'h4, C_START = 32'h5, C_DESYNC = 32'hD;
  localparam logic [31:0] RBASE = 32'hA000_0000;

  logic clk = 0, rst_n = 0, start = 0, done = 0, m_ready = 1;
  logic [31:0] addr = 0;
  logic [7:0] wpf = 0, fc = 0;
  logic port_wr, port_rd, m_valid, busy, timeout;
  logic [31:0] port_wdata, port_rdata, m_data;

  int checks = 0, errors = 0, cyc = 0;
  int ph = 0, idx = 0, ridx = 0, wcnt = 0, m_len = 0, m_wpf = 0, m_to = 0;
  logic [31:0] m_addr = 0;
  int rmode = 0, ddelay = 0, dnever = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_readback_seq #(.TIMEOUT_CYCLES(TO_CYC), .SYNC_WORD(W_SYNC), .NOOP_WORD(W_NOOP),
    .DUMMY_WORD(W_DUMMY), .CMD_HDR(H_CMD), .FAR_HDR(H_FAR), .FDRO_HDR(H_FDRO),
    .TYPE2_RD_HDR(H_T2), .RCRC_CODE(C_RCRC), .SHUTDOWN_CODE(C_SHUT),
    .RCFG_CODE(C_RCFG), .START_CODE(C_START), .DESYNC_CODE(C_DESYNC)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .frame_addr_i(addr),
    .words_per_frame_i(wpf), .frame_count_i(fc), .port_wr_o(port_wr),
    .port_wdata_o(port_wdata), .port_rd_o(port_rd), .port_rdata_i(port_rdata),
    .done_i(done), .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data),
    .busy_o(busy), .timeout_o(timeout));

  assign port_rdata = RBASE + 32'(ridx);

  function automatic logic [31:0] pre_word(int i);
    case (i)
      0: return W_SYNC;
      2, 6, 12: return H_CMD;
      3: return C_RCRC;
      7: return C_SHUT;
      13: return C_RCFG;
      14: return H_FAR;
      15: return m_addr;
      16: return H_FDRO;
      17: return H_T2 | 32'(m_len);
      18, 19: return W_DUMMY;
      default: return W_NOOP;
    endcase
  endfunction

  function automatic logic [31:0] post_word(int i);
    case (i)
      1, 3, 5: return H_CMD;
      2: return C_START;
      4: return C_RCRC;
      6: return C_DESYNC;
      default: return W_NOOP;
    endcase
  endfunction

  function automatic bit in_win();
    return (ridx >= m_wpf) && (ridx < m_len - 1);
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // reference model, steps at each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      ph = 0; m_to = 0;
    end else begin
      case (ph)
        0: if (start) begin
          ph = 1; idx = 0; m_to = 0; m_addr = addr; m_wpf = int'(wpf);
          m_len = int'(wpf) * (int'(fc) + 1) + 1;
        end
        1: if (idx == 19) begin ph = 2; ridx = 0; end else idx++;
        2: if (!in_win() || m_ready) begin
          if (ridx == m_len - 1) begin ph = 3; idx = 0; end else ridx++;
        end
        3: if (idx == 8) begin ph = 4; wcnt = 0; end else idx++;
        4: if (done) ph = 0;
           else if (wcnt == TO_CYC - 1) begin ph = 0; m_to = 1; end
           else wcnt++;
        default: ph = 0;
      endcase
    end
  end

  // environment drive shortly after the rising edge
  always @(posedge clk) begin
    #2;
    m_ready = (rmode == 0) ? 1'b1 : (cyc % 3 != 0);
    done = (ph == 4) && !dnever && (wcnt >= ddelay);
  end

  // compare at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_wr, exp_rd, exp_v;
      logic [31:0] exp_w;
      string tag;
      exp_wr = (ph == 1) || (ph == 3) || (ph == 4);
      exp_w = (ph == 1) ? pre_word(idx) : (ph == 3) ? post_word(idx) : W_NOOP;
      exp_v = (ph == 2) && in_win();
      exp_rd = (ph == 2) && (!in_win() || m_ready);
      tag = (ph == 1) ? ((idx == 17) ? "R3" : (idx == 15) ? "R11" : "R2")
          : (ph == 3) ? "R7" : (ph == 4) ? "R8" : "R4";
      check(port_wr === exp_wr, tag, "port_wr", 32'(port_wr), 32'(exp_wr));
      if (exp_wr) check(port_wdata === exp_w, tag, "port_wdata", port_wdata, exp_w);
      check(port_rd === exp_rd, exp_v ? "R6" : "R4", "port_rd", 32'(port_rd), 32'(exp_rd));
      check(m_valid === exp_v, "R5", "m_valid", 32'(m_valid), 32'(exp_v));
      if (exp_v) check(m_data === RBASE + 32'(ridx), "R5", "m_data", m_data, RBASE + 32'(ridx));
      check(busy === (ph != 0), "R9", "busy", 32'(busy), 32'(ph != 0));
      check(timeout === 1'(m_to), "R10", "timeout", 32'(timeout), 32'(m_to));
    end
  end

  task automatic run(logic [31:0] a, int w, int f, int rm, int dd, int dn, bit restart);
    rmode = rm; ddelay = dd; dnever = dn;
    @(posedge clk); #2;
    addr = a; wpf = 8'(w); fc = 8'(f); start = 1;
    @(posedge clk); #2;
    start = 0;
    if (restart) begin   // R11: ignored start with different inputs
      repeat (4) @(posedge clk);
      #2; addr = 32'hDEAD_BEEF; wpf = 8'd7; fc = 8'd5; start = 1;
      @(posedge clk); #2; start = 0;
    end
    while (ph != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(!busy && !timeout && !port_wr && !port_rd && !m_valid, "R1", "reset outputs",
          {27'd0, busy, timeout, port_wr, port_rd, m_valid}, 32'd0);
    rst_n = 1;
    run(32'h0000_0000, 3, 2, 0, 5, 0, 0);
    run(32'h0012_3400, 4, 3, 1, 0, 0, 1);
    run(32'h0000_0100, 1, 0, 0, 0, 1, 0);   // R10: done never rises
    run(32'h0040_0000, 2, 1, 1, 2, 0, 0);   // timeout cleared on new start
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule